// File: doc/BRIEF.md
# Strobe-Latched SRAM Cycle Sequencer

This block sits between a simple host port and a small static RAM of 256 words by 4 bits whose address is latched on the falling edge of its enable strobe and whose data pins are shared between reading and writing. A host asks for a single read or a single write with a one-clock request pulse. The sequencer then produces the enable, two active-low selects, an active-low write strobe, the address, and the write data with its own output-enable. When the transfer ends it returns a one-clock acknowledge, and for a read it also returns the word it captured.

Every timing interval of the RAM is a parameter counted in system clocks: address setup, address hold, enable low width, enable high (precharge) width, fall-to-fall cycle time, enable access time, data setup, data hold and write pulse width. The control edges are ordered so the RAM and the sequencer never drive the shared data lines together. On a write the write strobe falls before the selects, and at the end of a write the selects rise before the write strobe. On a read the sequencer's data driver is already off before the selects fall.

Top module: `strobe_ram_seq`

## Requirements
- R1: While reset is held and until the first request, the enable, both selects and the write strobe are high (1), the data driver enable is 0 and the acknowledge is 0.
- R2: A request is accepted only in the idle state. A request raised while a transfer is in progress, or in the acknowledge cycle, starts no RAM cycle, produces no acknowledge and changes no memory word.
- R3: The address is stable for at least T_ASU clocks before the enable falls, and it does not change while the enable is low.
- R4: The enable stays low for at least max(T_ELOW, T_AH) clocks in every transfer.
- R5: The enable stays high for at least T_EHIGH clocks before each falling edge.
- R6: Two successive falling edges of the enable are at least T_CYC clocks apart.
- R7: On a read, the write strobe stays high and both selects go low together while the enable is low. The data lines are sampled at the end of the clock that ends at least T_ACC clocks after the enable fell. That word is returned on host_rdata with the acknowledge.
- R8: On a write, the write strobe falls while both selects are high. The selects fall only after the write strobe is low, so at no clock are the enable, both selects low and the write strobe high while the data driver is on.
- R9: On a write, the enable, both selects and the write strobe are all low together for at least T_WP clocks. The data driver is on with the write data for at least T_DSU clocks before the selects rise.
- R10: At the end of a write, the selects rise while the write strobe is still low. The data stays driven for at least T_DH clocks after the selects rise. The driver turns off in the same clock that the write strobe and the enable return high.
- R11: On a read, the data driver enable is 0 in the clock before the selects fall.
- R12: Each accepted request gives exactly one acknowledge, one clock wide, in the first clock after the enable returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_req | input | 1 | One-clock request pulse, sampled only when idle |
| host_we | input | 1 | 1 = write, 0 = read, qualified by host_req |
| host_addr | input | ADDR_W | Word address of the request |
| host_wdata | input | DATA_W | Write data of the request |
| host_ack | output | 1 | One-clock completion pulse |
| host_rdata | output | DATA_W | Word captured by the last read |
| mem_addr | output | ADDR_W | Address to the RAM, held for the whole transfer |
| mem_en_n | output | 1 | RAM enable strobe, active low, address latched on its fall |
| mem_cs_a_n | output | 1 | First RAM select, active low |
| mem_cs_b_n | output | 1 | Second RAM select, active low |
| mem_wr_n | output | 1 | RAM write strobe, active low |
| mem_dout | output | DATA_W | Write data toward the shared data lines |
| mem_doe | output | 1 | 1 = sequencer drives mem_dout onto the data lines |
| mem_din | input | DATA_W | Data lines as seen from the RAM side |

## Verification
The bench writes every one of the 256 addresses and reads each one back, with a behavioural RAM that returns the inverted word until the access count has elapsed. A sequencer that sampled one clock early would read back wrong data at every address. The RAM model also flags any clock in which both sides drive the data lines, and it times each enable, select and write edge against the parameter counts. A sequencer that raised the write strobe before the selects, released the data too soon, or skipped the precharge or cycle-time wait fails at its first transfer. Requests raised during a transfer and in the acknowledge cycle are then followed by read-backs and an edge count, so a sequencer that accepted them would show an extra RAM cycle or a changed word.

// File: rtl/strobe_ram_seq_pkg.sv
package strobe_ram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_SETUP    = 3'd1,
    ST_RD_ACC   = 3'd2,
    ST_WR_ARM   = 3'd3,
    ST_WR_PULSE = 3'd4,
    ST_WR_HOLD  = 3'd5,
    ST_DONE     = 3'd6
  } seq_state_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/seq_phase_timer.sv
// Down counter that times the current phase; loaded on each phase entry.
module seq_phase_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/seq_spacing_guard.sv
// Tracks enable-high run and time since the last enable fall; ok when both
// minimums are met if the enable falls at the end of the current clock.
module seq_spacing_guard #(
  parameter int CW     = 5,
  parameter int HI_MIN = 3,
  parameter int CY_MIN = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic e_low,
  input  logic e_fall,
  output logic ok
);
  localparam logic [CW-1:0] HI_LIM = CW'((HI_MIN > 0) ? HI_MIN - 1 : 0);
  localparam logic [CW-1:0] CY_LIM = CW'((CY_MIN > 0) ? CY_MIN - 1 : 0);

  logic [CW-1:0] hi_run_q, hi_run_d;
  logic [CW-1:0] cy_run_q, cy_run_d;

  always_comb begin
    if (e_low)                hi_run_d = '0;
    else if (hi_run_q == '1)  hi_run_d = hi_run_q;
    else                      hi_run_d = hi_run_q + 1'b1;

    if (e_fall)               cy_run_d = '0;
    else if (cy_run_q == '1)  cy_run_d = cy_run_q;
    else                      cy_run_d = cy_run_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run_q <= '1;
      cy_run_q <= '1;
    end else begin
      hi_run_q <= hi_run_d;
      cy_run_q <= cy_run_d;
    end
  end

  assign ok = (hi_run_q >= HI_LIM) && (cy_run_q >= CY_LIM);
endmodule

// File: rtl/strobe_ram_seq.sv
module strobe_ram_seq
  import strobe_ram_seq_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 4,
  parameter int T_ASU   = 1,
  parameter int T_AH    = 2,
  parameter int T_ELOW  = 4,
  parameter int T_EHIGH = 3,
  parameter int T_CYC   = 10,
  parameter int T_ACC   = 5,
  parameter int T_DSU   = 3,
  parameter int T_DH    = 1,
  parameter int T_WP    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_ack,
  output logic [DATA_W-1:0] host_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_en_n,
  output logic              mem_cs_a_n,
  output logic              mem_cs_b_n,
  output logic              mem_wr_n,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_doe,
  input  logic [DATA_W-1:0] mem_din
);
  // Phase lengths in clocks, each at least one.
  localparam int ELOW_MIN = imax(T_ELOW, T_AH);
  localparam int N_ASU    = imax(T_ASU, 1);
  localparam int N_RD     = imax(imax(T_ACC, ELOW_MIN), 1);
  localparam int N_WP     = imax(imax(T_WP, T_DSU), 1);
  localparam int N_WH     = imax(imax(T_DH, 1), ELOW_MIN - 1 - N_WP);
  localparam int MAXD     = imax(imax(imax(N_ASU, N_RD), imax(N_WP, N_WH)),
                                 imax(T_EHIGH, T_CYC));
  localparam int CW       = $clog2(MAXD + 2);

  // Reset: asserted asynchronously, released on the clock.
  logic rst_meta_q, rst_n_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_q    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_q    <= rst_meta_q;
    end
  end

  seq_state_e        state_q, state_d;
  logic              op_we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;

  logic              accept, capture, e_fall, e_low;
  logic              tmr_load, tmr_done, space_ok;
  logic [CW-1:0]     tmr_val;

  seq_phase_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n_q),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  seq_spacing_guard #(.CW(CW), .HI_MIN(T_EHIGH), .CY_MIN(T_CYC)) u_guard (
    .clk    (clk),
    .rst_n  (rst_n_q),
    .e_low  (e_low),
    .e_fall (e_fall),
    .ok     (space_ok)
  );

  // Next-state logic.
  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    accept   = 1'b0;
    capture  = 1'b0;
    e_fall   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (host_req) begin
          accept   = 1'b1;
          state_d  = ST_SETUP;
          tmr_load = 1'b1;
          tmr_val  = CW'(N_ASU - 1);
        end
      end
      ST_SETUP: begin
        if (tmr_done && space_ok) begin
          e_fall   = 1'b1;
          tmr_load = 1'b1;
          if (op_we_q) begin
            state_d = ST_WR_ARM;
            tmr_val = '0;
          end else begin
            state_d = ST_RD_ACC;
            tmr_val = CW'(N_RD - 1);
          end
        end
      end
      ST_RD_ACC: begin
        if (tmr_done) begin
          capture = 1'b1;
          state_d = ST_DONE;
        end
      end
      ST_WR_ARM: begin
        if (tmr_done) begin
          state_d  = ST_WR_PULSE;
          tmr_load = 1'b1;
          tmr_val  = CW'(N_WP - 1);
        end
      end
      ST_WR_PULSE: begin
        if (tmr_done) begin
          state_d  = ST_WR_HOLD;
          tmr_load = 1'b1;
          tmr_val  = CW'(N_WH - 1);
        end
      end
      ST_WR_HOLD: begin
        if (tmr_done) state_d = ST_DONE;
      end
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  // Registers.
  always_ff @(posedge clk or negedge rst_n_q) begin
    if (!rst_n_q) state_q <= ST_IDLE;
    else          state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n_q) begin
    if (!rst_n_q) begin
      op_we_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      op_we_q <= host_we;
      addr_q  <= host_addr;
      wdata_q <= host_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n_q) begin
    if (!rst_n_q)     rdata_q <= '0;
    else if (capture) rdata_q <= mem_din;
  end

  // Strobe decode from the state register.
  logic sel_low, wr_low;
  always_comb begin
    e_low   = (state_q == ST_RD_ACC)   || (state_q == ST_WR_ARM) ||
              (state_q == ST_WR_PULSE) || (state_q == ST_WR_HOLD);
    sel_low = (state_q == ST_RD_ACC)   || (state_q == ST_WR_PULSE);
    wr_low  = (state_q == ST_WR_ARM)   || (state_q == ST_WR_PULSE) ||
              (state_q == ST_WR_HOLD);
  end

  assign mem_en_n   = ~e_low;
  assign mem_cs_a_n = ~sel_low;
  assign mem_cs_b_n = ~sel_low;
  assign mem_wr_n   = ~wr_low;
  assign mem_doe    = op_we_q && ((state_q == ST_SETUP) || wr_low);
  assign mem_dout   = wdata_q;
  assign mem_addr   = addr_q;
  assign host_ack   = (state_q == ST_DONE);
  assign host_rdata = rdata_q;

endmodule

// File: rtl/strobe_ram_seq_chk.sv
module strobe_ram_seq_chk #(
  parameter int ADDR_W   = 8,
  parameter int ELOW_MIN = 4,
  parameter int T_EHIGH  = 3,
  parameter int T_CYC    = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_en_n,
  input logic              mem_cs_a_n,
  input logic              mem_cs_b_n,
  input logic              mem_wr_n,
  input logic              mem_doe
);
  int hi_cnt, lo_cnt, cy_cnt;
  logic en_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt  <= 100000;
      lo_cnt  <= 0;
      cy_cnt  <= 100000;
      en_prev <= 1'b1;
    end else begin
      en_prev <= mem_en_n;
      hi_cnt  <= mem_en_n ? ((hi_cnt < 100000) ? hi_cnt + 1 : hi_cnt) : 0;
      lo_cnt  <= mem_en_n ? 0 : lo_cnt + 1;
      cy_cnt  <= (en_prev && !mem_en_n) ? 1
               : ((cy_cnt < 100000) ? cy_cnt + 1 : cy_cnt);
    end
  end

  a_r3_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_en_n && $past(!mem_en_n)) |-> $stable(mem_addr));

  a_r4_low_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_en_n) |-> (lo_cnt >= ELOW_MIN));

  a_r5_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_en_n) |-> (hi_cnt >= T_EHIGH));

  a_r6_cycle_time: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_en_n) |-> (cy_cnt >= T_CYC));

  a_r8_we_first: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_wr_n) |-> (mem_cs_a_n && mem_cs_b_n));

  a_r8_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_en_n && !mem_cs_a_n && !mem_cs_b_n && mem_wr_n) |-> !mem_doe);

  a_r10_sel_rise_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wr_n) |-> ($past(mem_cs_a_n) && $past(mem_cs_b_n)));

  a_r11_driver_off: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mem_cs_a_n) && mem_wr_n) |-> !$past(mem_doe));

  a_r12_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |=> !host_ack);

endmodule

bind strobe_ram_seq strobe_ram_seq_chk #(
  .ADDR_W   (ADDR_W),
  .ELOW_MIN ((T_ELOW > T_AH) ? T_ELOW : T_AH),
  .T_EHIGH  (T_EHIGH),
  .T_CYC    (T_CYC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_ack   (host_ack),
  .mem_addr   (mem_addr),
  .mem_en_n   (mem_en_n),
  .mem_cs_a_n (mem_cs_a_n),
  .mem_cs_b_n (mem_cs_b_n),
  .mem_wr_n   (mem_wr_n),
  .mem_doe    (mem_doe)
);

// File: tb/strobe_ram_seq_tb.sv
`timescale 1ns/1ps
module strobe_ram_seq_tb;
  localparam int T_ASU = 1, T_ELOW = 4, T_EHIGH = 3, T_CYC = 10;
  localparam int T_ACC = 5, T_DSU = 3, T_DH = 1, T_WP = 3;
  localparam int ELOW_MIN = 4;

  logic       clk, rst_n;
  logic       host_req, host_we, host_ack;
  logic [7:0] host_addr, mem_addr;
  logic [3:0] host_wdata, host_rdata, mem_dout, mem_din;
  logic       mem_en_n, mem_cs_a_n, mem_cs_b_n, mem_wr_n, mem_doe;

  strobe_ram_seq u_dut (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_ack(host_ack),
    .host_rdata(host_rdata), .mem_addr(mem_addr), .mem_en_n(mem_en_n),
    .mem_cs_a_n(mem_cs_a_n), .mem_cs_b_n(mem_cs_b_n), .mem_wr_n(mem_wr_n),
    .mem_dout(mem_dout), .mem_doe(mem_doe), .mem_din(mem_din)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0, failures = 0;
  int ack_cnt = 0, fall_cnt = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] pat(input int a);
    return 4'(((a * 5) ^ (a >> 3)) & 15);
  endfunction

  // Behavioural RAM and edge-timing monitor, evaluated at falling clock edges.
  logic [3:0] ram [256];
  logic [7:0] lat, p_addr;
  logic p_en = 1'b1, p_cs = 1'b1, p_wr = 1'b1, p_doe = 1'b0, p_all = 1'b0;
  logic wr_at_rise = 1'b0, in_hold = 1'b0;
  bit   seen_fall = 1'b0;
  int   hi_run = 1000, lo_run = 0, since_fall = 0, addr_run = 1000;
  int   wp_run = 0, doe_run = 0, dh_run = 0;

  initial begin
    for (int i = 0; i < 256; i++) ram[i] = ~pat(i);
    mem_din = 4'h0;
    lat = 8'h00;
    p_addr = 8'h00;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      automatic logic all_low = !mem_en_n && !mem_cs_a_n && !mem_wr_n;
      if (host_ack) ack_cnt++;
      check(mem_cs_a_n == mem_cs_b_n, "R7 selects together", mem_cs_a_n, mem_cs_b_n);
      if (!mem_en_n && !mem_cs_a_n && mem_wr_n && mem_doe)
        check(1'b0, "R8 bus contention", 1, 0);
      // enable falling edge
      if (p_en && !mem_en_n) begin
        fall_cnt++;
        check(hi_run >= T_EHIGH, "R5 precharge", hi_run, T_EHIGH);
        if (seen_fall) check(since_fall >= T_CYC, "R6 cycle time", since_fall, T_CYC);
        check(addr_run >= T_ASU, "R3 address setup", addr_run, T_ASU);
        lat = mem_addr;
        lo_run = 0;
        since_fall = 0;
        seen_fall = 1'b1;
      end
      if (!p_en && mem_en_n)
        check(lo_run >= ELOW_MIN, "R4 enable low width", lo_run, ELOW_MIN);
      if (!p_en && !mem_en_n)
        check(mem_addr == p_addr, "R3 address held", mem_addr, p_addr);
      // select falling edge
      if (p_cs && !mem_cs_a_n) begin
        if (mem_doe) check(!mem_wr_n && !p_wr, "R8 write strobe before selects", p_wr, 0);
        else begin
          check(mem_wr_n, "R7 write strobe high on read", mem_wr_n, 1);
          check(!p_doe, "R11 driver off before selects", p_doe, 0);
        end
      end
      // run counters
      if (!mem_en_n) lo_run++;
      since_fall++;
      hi_run   = mem_en_n ? (p_en ? hi_run + 1 : 1) : 0;
      addr_run = (mem_addr == p_addr) ? addr_run + 1 : 1;
      doe_run  = mem_doe ? doe_run + 1 : 0;
      // write pulse and select rise
      if (all_low) wp_run++;
      else if (p_all) begin
        check(wp_run >= T_WP, "R9 write pulse width", wp_run, T_WP);
        check(doe_run - 1 >= T_DSU, "R9 data setup", doe_run - 1, T_DSU);
        check(!mem_wr_n, "R10 selects rise before write strobe", mem_wr_n, 0);
        wp_run = 0;
        dh_run = 0;
        in_hold = 1'b1;
      end
      if (in_hold && mem_doe) dh_run++;
      if (p_doe && !mem_doe) begin
        check(dh_run >= T_DH, "R10 data hold", dh_run, T_DH);
        check(mem_wr_n && mem_en_n, "R10 driver off with strobe rise", mem_wr_n, 1);
        in_hold = 1'b0;
      end
      // memory array behaviour
      if (all_low && mem_doe) ram[lat] = mem_dout;
      if (!mem_en_n && !mem_cs_a_n && mem_wr_n)
        mem_din = (lo_run >= T_ACC) ? ram[lat] : ~ram[lat];
      else
        mem_din = 4'h0;
      p_en = mem_en_n; p_cs = mem_cs_a_n; p_wr = mem_wr_n;
      p_doe = mem_doe; p_all = all_low; p_addr = mem_addr;
    end
  end

  task automatic xfer(input bit we, input logic [7:0] a, input logic [3:0] d,
                      output logic [3:0] rd);
    bit got = 1'b0;
    @(negedge clk);
    host_req = 1'b1; host_we = we; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_req = 1'b0;
    for (int k = 0; k < 200; k++) begin
      if (host_ack) begin got = 1'b1; break; end
      @(negedge clk);
    end
    check(got, "R12 acknowledge arrives", got, 1);
    rd = host_rdata;
    @(negedge clk);
    check(!host_ack, "R12 acknowledge one clock", host_ack, 0);
  endtask

  task automatic check_idle(input string tag);
    check(mem_en_n && mem_cs_a_n && mem_cs_b_n && mem_wr_n, tag,
          {mem_en_n, mem_cs_a_n, mem_cs_b_n, mem_wr_n}, 15);
    check(!mem_doe && !host_ack, tag, {mem_doe, host_ack}, 0);
  endtask

  initial begin
    logic [3:0] rd;
    int ops, ack_before;
    rst_n = 1'b0; host_req = 1'b0; host_we = 1'b0;
    host_addr = 8'h00; host_wdata = 4'h0;
    repeat (3) @(negedge clk);
    check_idle("R1 reset state");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_idle("R1 idle after reset");
    check(ack_cnt == 0 && fall_cnt == 0, "R1 no activity", fall_cnt, 0);

    // Full sweep: write every word, then read each back.
    for (int a = 0; a < 256; a++) xfer(1'b1, 8'(a), pat(a), rd);
    for (int a = 0; a < 256; a++) begin
      xfer(1'b0, 8'(a), 4'h0, rd);
      check(rd == pat(a), "R7 read back", rd, pat(a));
    end
    ops = 512;

    // Requests while busy and in the acknowledge cycle are ignored.
    ack_before = ack_cnt;
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b1; host_addr = 8'h10; host_wdata = 4'h3;
    @(negedge clk);
    host_req = 1'b0;
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b1; host_addr = 8'h20; host_wdata = ~pat(8'h20);
    @(negedge clk);
    host_req = 1'b0;
    for (int k = 0; k < 200; k++) begin
      if (host_ack) break;
      @(negedge clk);
    end
    host_req = 1'b1; host_we = 1'b1; host_addr = 8'h21; host_wdata = ~pat(8'h21);
    @(negedge clk);
    host_req = 1'b0;
    repeat (30) @(negedge clk);
    ops++;
    check(ack_cnt == ack_before + 1, "R2 single acknowledge", ack_cnt - ack_before, 1);
    check(fall_cnt == ops, "R2 enable cycles", fall_cnt, ops);
    xfer(1'b0, 8'h20, 4'h0, rd);
    check(rd == pat(8'h20), "R2 busy request dropped", rd, pat(8'h20));
    xfer(1'b0, 8'h21, 4'h0, rd);
    check(rd == pat(8'h21), "R2 ack-cycle request dropped", rd, pat(8'h21));
    xfer(1'b0, 8'h10, 4'h0, rd);
    check(rd == 4'h3, "R7 accepted write read back", rd, 3);
    ops += 3;

    // Overwrite and alternate write/read on the same word.
    for (int v = 0; v < 16; v++) begin
      xfer(1'b1, 8'h55, 4'(v), rd);
      xfer(1'b0, 8'h55, 4'h0, rd);
      check(rd == 4'(v), "R9 overwrite read back", rd, v);
    end
    ops += 32;
    check(fall_cnt == ops, "R12 one cycle per request", fall_cnt, ops);
    check(ack_cnt == ops, "R12 one acknowledge per request", ack_cnt, ops);
    check_idle("R1 idle at end");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule